// File: doc/BRIEF.md
# Carry-Skip Adder/Subtractor

A purely combinational 32-bit adder/subtractor. The operand width is split into equal-width blocks. Inside each block the carry ripples from bit to bit. A 2:1 selector beside each block forms the carry passed to the next block. When every bit of the block propagates, it passes on the block's incoming carry directly. In every other case it passes on the carry that rippled through the block. This shortens the worst-case carry path compared with a full ripple chain, and the skip logic stays small.

A mode input chooses between addition and subtraction. In subtract mode the B operand is inverted bit by bit and the effective carry-in is forced to one, so the result is A minus B in two's complement. The block also exposes one group-propagate flag per block. These flags show which blocks would let a carry bypass them for the present operands.

Top module: `carry_skip_addsub`

## Requirements
- R1: With `sub_mode`=0, {`carry_out`,`sum`} equals `op_a` + `op_b` + `carry_in` as an unsigned 33-bit value.
- R2: With `sub_mode`=1, `sum` equals (`op_a` - `op_b`) modulo 2^32.
- R3: With `sub_mode`=1, `carry_out` is 1 exactly when `op_a` >= `op_b` as unsigned numbers (no borrow), and `carry_in` has no effect on `sum` or `carry_out`.
- R4: `grp_prop[k]` is 1 exactly when all eight bits `op_a[8k+7:8k]` XOR `beff[8k+7:8k]` are 1. Here `beff` is `op_b` when adding and ~`op_b` when subtracting. Bit 0 covers the least significant block.
- R5: When every group-propagate flag is 1, `carry_out` equals the effective carry-in (`carry_in` when adding, 1 when subtracting) and `sum` is all ones XOR that carry replicated.
- R6: Carries cross every block boundary. All-ones plus carry-in 1 gives `sum` 0 and `carry_out` 1. Zero minus one gives all ones and `carry_out` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand (subtrahend in subtract mode) |
| carry_in | input | 1 | Carry into bit 0 when adding; ignored when subtracting |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| sum | output | 32 | Result |
| carry_out | output | 1 | Carry out of the top bit (1 = no borrow when subtracting) |
| grp_prop | output | 4 | Group-propagate flag of each 8-bit block |

## Verification
Operands with A equal to the inverse of B make every block propagate. This sends the carry along the full skip path and separates a broken selector from a working ripple. All-ones plus one and zero minus one force a carry or borrow through every bit of every block. They show whether the block boundaries pass carries correctly. Alternating bit patterns and single-block propagate cases mix skipping and non-skipping blocks, so a wrong skip decision in one block corrupts only the higher blocks. Random vectors in both modes, with the carry-in toggled while subtracting, cover the general sum and borrow relations and show that the carry-in is ignored in subtract mode.

// File: rtl/csa_pkg.sv
package csa_pkg;
  typedef struct packed {
    logic p;
    logic g;
  } pg_t;

  // Bit propagate and generate of one effective operand pair
  function automatic pg_t bit_pg(input logic a, input logic b);
    pg_t r;
    r.p = a ^ b;
    r.g = a & b;
    return r;
  endfunction

  // Operand conditioning for two's-complement subtraction
  function automatic logic cond_b(input logic b, input logic sub);
    return b ^ sub;
  endfunction
endpackage

// File: rtl/csa_operand_prep.sv
module csa_operand_prep
  import csa_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic             sub,
  output logic [WIDTH-1:0] p,
  output logic [WIDTH-1:0] g,
  output logic             cin_eff
);
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      pg_t pg;
      assign pg   = bit_pg(a[i], cond_b(b[i], sub));
      assign p[i] = pg.p;
      assign g[i] = pg.g;
    end
  endgenerate

  assign cin_eff = sub | cin;
endmodule

// File: rtl/csa_block.sv
module csa_block #(
  parameter int BW = 8
) (
  input  logic [BW-1:0] p,
  input  logic [BW-1:0] g,
  input  logic          c_in,
  output logic [BW-1:0] s,
  output logic          c_out,
  output logic          gp
);
  logic ripple_out;

  always_comb begin
    logic cr;
    cr = c_in;
    for (int i = 0; i < BW; i++) begin
      s[i] = p[i] ^ cr;
      cr   = g[i] | (p[i] & cr);
    end
    ripple_out = cr;
  end

  assign gp    = &p;
  assign c_out = gp ? c_in : ripple_out;

  // Assertions next to the skip selector
  always_comb begin
    AST_SKIP_AGREES: assert (c_out == ripple_out)
      else $error("skip carry disagrees with ripple carry"); // R5
    AST_GP_NO_GEN: assert (!gp || (g == '0))
      else $error("propagating block also generates"); // R4
  end
endmodule

// File: rtl/carry_skip_addsub.sv
module carry_skip_addsub #(
  parameter int WIDTH = 32,
  parameter int BLK   = 8
) (
  input  logic [WIDTH-1:0]     op_a,
  input  logic [WIDTH-1:0]     op_b,
  input  logic                 carry_in,
  input  logic                 sub_mode,
  output logic [WIDTH-1:0]     sum,
  output logic                 carry_out,
  output logic [WIDTH/BLK-1:0] grp_prop
);
  localparam int NBLK = WIDTH / BLK;

  generate
    if ((WIDTH % BLK) != 0) begin : g_bad_width
      $error("block width must divide operand width");
    end
  endgenerate

  logic [WIDTH-1:0] bit_p;
  logic [WIDTH-1:0] bit_g;
  logic             cin_eff;
  logic [NBLK:0]    blk_c;

  csa_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .a       (op_a),
    .b       (op_b),
    .cin     (carry_in),
    .sub     (sub_mode),
    .p       (bit_p),
    .g       (bit_g),
    .cin_eff (cin_eff)
  );

  assign blk_c[0] = cin_eff;

  genvar k;
  generate
    for (k = 0; k < NBLK; k++) begin : g_blk
      csa_block #(.BW(BLK)) u_blk (
        .p     (bit_p[k*BLK +: BLK]),
        .g     (bit_g[k*BLK +: BLK]),
        .c_in  (blk_c[k]),
        .s     (sum[k*BLK +: BLK]),
        .c_out (blk_c[k+1]),
        .gp    (grp_prop[k])
      );
    end
  endgenerate

  assign carry_out = blk_c[NBLK];

  // Arithmetic cross-checks of the structural result
  logic [WIDTH:0] ref_add;
  logic [WIDTH-1:0] ref_dif;
  assign ref_add = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
  assign ref_dif = op_a - op_b;

  always_comb begin
    AST_ADD_RESULT: assert (sub_mode || ({carry_out, sum} == ref_add))
      else $error("add result mismatch"); // R1
    AST_SUB_RESULT: assert (!sub_mode || (sum == ref_dif))
      else $error("subtract result mismatch"); // R2
    AST_NO_BORROW: assert (!sub_mode || (carry_out == (op_a >= op_b)))
      else $error("borrow flag mismatch"); // R3
    AST_FULL_SKIP: assert (!(&grp_prop) || (carry_out == cin_eff))
      else $error("full skip carry mismatch"); // R5
  end
endmodule

// File: tb/tb_carry_skip_addsub.sv
module tb_carry_skip_addsub;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        carry_in = 1'b0;
  logic        sub_mode = 1'b0;
  logic [31:0] sum;
  logic        carry_out;
  logic [3:0]  grp_prop;

  carry_skip_addsub dut (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .sub_mode(sub_mode),
    .sum(sum), .carry_out(carry_out), .grp_prop(grp_prop)
  );

  typedef struct {
    logic [31:0] s;
    logic        c;
    logic [3:0]  gp;
    string       tag;
  } exp_t;

  exp_t q[$];
  int tests = 0;
  int fails = 0;
  bit done = 0;

  task automatic drive(input logic [31:0] a, input logic [31:0] b,
                       input logic ci, input logic sb, input string tag);
    exp_t e;
    logic [31:0] be;
    @(negedge clk);
    op_a = a; op_b = b; carry_in = ci; sub_mode = sb;
    if (sb) begin
      e.s = a - b;
      e.c = (a >= b);
    end else begin
      {e.c, e.s} = 33'(a) + 33'(b) + 33'(ci);
    end
    be = sb ? ~b : b;
    for (int k = 0; k < 4; k++) e.gp[k] = ((a[k*8 +: 8] ^ be[k*8 +: 8]) == 8'hFF);
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compare one item per cycle, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        tests++;
        if (sum !== e.s || carry_out !== e.c || grp_prop !== e.gp) begin
          fails++;
          $display("FAIL %s: sum=%h cout=%b gp=%b expected sum=%h cout=%b gp=%b",
                   e.tag, sum, carry_out, grp_prop, e.s, e.c, e.gp);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset/idle state with zero inputs
    drive(32'h0, 32'h0, 1'b0, 1'b0, "R1 idle zero");
    // R1 add cases
    drive(32'h0000_0001, 32'h0000_0002, 1'b0, 1'b0, "R1 small add");
    drive(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, "R1 top carry");
    drive(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0, 1'b0, "R1 alternating");
    // R6 wrap corner cases
    drive(32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0, "R6 ones plus cin");
    drive(32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0, "R6 ones plus one");
    drive(32'h0, 32'h1, 1'b0, 1'b1, "R6 zero minus one");
    // R5 full skip path (a = ~b)
    drive(32'h1234_5678, ~32'h1234_5678, 1'b1, 1'b0, "R5 skip add cin1");
    drive(32'h5555_5555, 32'hAAAA_AAAA, 1'b0, 1'b0, "R5 skip add cin0");
    drive(32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, 1'b1, "R5 skip sub");
    // R4 mixed per-block propagate
    drive(32'h00FF_00FF, 32'h0000_FF00, 1'b0, 1'b0, "R4 mixed blocks");
    drive(32'hFF00_0000, 32'h0000_0000, 1'b1, 1'b0, "R4 top block only");
    drive(32'h0F0F_0F0F, 32'h0F0F_0F0F, 1'b0, 1'b1, "R4 sub equal");
    // R2 / R3 subtract, carry_in ignored
    drive(32'h0000_0010, 32'h0000_0020, 1'b0, 1'b1, "R2 negative diff");
    drive(32'h0000_0010, 32'h0000_0020, 1'b1, 1'b1, "R3 cin ignored lt");
    drive(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b1, "R3 cin ignored ge");
    drive(32'h5555_5555, 32'hAAAA_AAAA, 1'b0, 1'b1, "R2 alternating sub");
    for (int i = 0; i < 300; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom; rb = $urandom;
      drive(ra, rb, 1'($urandom), 1'b0, "R1 random add");
      drive(ra, rb, 1'($urandom), 1'b1, "R2 random sub");
    end
    repeat (3) @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule